// File: doc/BRIEF.md
# Network controller status register file

This block is the host-visible register file of an Ethernet DMA controller that serves eight transmit and eight receive descriptor rings. A host reads and writes 32-bit words over a simple request/write-enable bus that covers a 4 KB window. Each register has its own access policy: read/write, write-only, write-one-to-clear or read-only. Writes to undefined words are dropped, and reads of undefined words return zero.

Three registers carry more than storage. The interrupt event register collects hardware event strobes, and software clears it bit by bit. The event register is combined with a mask register to drive three interrupt lines: transmit, receive and error. Each ring has a halt flag in one of two status registers. Clearing a halt flag sends a one-clock restart pulse to the ring engine. On the receive side the pulse goes out only when the flag was already clear. Writing a ring base register also loads that ring's current-descriptor pointer with the same 8-byte-aligned address.

Top module: `nic_stat_regfile`

## Requirements
- R1: After reset the registers hold these values. Event 0. Mask 0. Transmit status 0xFF000000 (all rings halted). Receive status 0x00FF0000. Config 0x00000100. Identity 0x0A5C0003. All base and pointer registers 0. The read data, the interrupt lines and the restart pulses are all 0.
- R2: The word index is addr_i[11:2]. A read (req_i=1, we_i=0) updates rdata_o at the next clock edge, and rdata_o holds its value until the next read. Reading an undefined index returns 0. Word map: 0 event, 1 mask, 2 transmit status, 3 receive status, 4 config, 5 command, 6 identity, 64+n transmit base, 72+n transmit pointer, 80+n receive base, 88+n receive pointer.
- R3: The command word (index 5) is write-only. Reading it returns 0, and the last value written to it appears on cmd_o.
- R4: The config word (index 4) and the mask (index 1) are read/write. A read returns the last value written, and the config value also appears on cfg_o.
- R5: Writes are ignored for the identity word (read-only), for the pointer registers (loaded only by base writes) and for undefined indices.
- R6: Writing the event register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: A 1 on evt_set_i[b] sets event bit b. When a software clear and a hardware set reach the same bit in the same cycle, the bit ends up set.
- R8: Each interrupt line is the OR of event AND mask over its own bit group: transmit bits 7:0, receive bits 15:8, error bits 31:16. A line follows a change to event or mask in the same clock edge that updates the register.
- R9: Transmit status bit 31-i is the halt flag of transmit ring i. Writing 1 to that bit clears the flag. It also drives tx_restart_o[i] high for exactly the cycle after the write, whether or not the flag was set. Several rings may pulse together.
- R10: Receive status bit 23-i is the halt flag of receive ring i. Writing 1 there pulses rx_restart_o[i] only when the flag was 0 before the write. The write then clears the flag.
- R11: tx_halt_set_i[i] and rx_halt_set_i[i] set the halt flag of ring i, and a set wins over a clear written in the same cycle.
- R12: A write to base register n stores the value with bits 2:0 forced to 0. The same write loads that value into pointer register n of the same direction, and the other rings are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_set_i | input | 32 | Per-bit hardware event strobes |
| tx_halt_set_i | input | 8 | Transmit ring halt strobes |
| rx_halt_set_i | input | 8 | Receive ring halt strobes |
| tx_restart_o | output | 8 | Transmit ring restart pulses |
| rx_restart_o | output | 8 | Receive ring restart pulses |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Error interrupt |
| cfg_o | output | 32 | Config word value |
| cmd_o | output | 32 | Command word value |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. Read data, restart pulses, cfg_o and cmd_o come straight from registers. The interrupt lines are decoded from the event and mask flops, so they change at the same edge as those flops. The bench changes inputs and compares outputs only on falling edges, so each write's effect is checked half a cycle after the rising edge that took it, and a restart pulse is checked once high and once low on consecutive falling edges. A behavioural model that updates on the same rising edge is compared against every output on every falling edge, during directed cases and during a random phase.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    localparam int IDX_W = 10;

    localparam logic [IDX_W-1:0] IDX_EVT = 10'd0;
    localparam logic [IDX_W-1:0] IDX_MSK = 10'd1;
    localparam logic [IDX_W-1:0] IDX_TXS = 10'd2;
    localparam logic [IDX_W-1:0] IDX_RXS = 10'd3;
    localparam logic [IDX_W-1:0] IDX_CFG = 10'd4;
    localparam logic [IDX_W-1:0] IDX_CMD = 10'd5;
    localparam logic [IDX_W-1:0] IDX_ID  = 10'd6;
    localparam logic [IDX_W-1:0] IDX_TXB = 10'd64;
    localparam logic [IDX_W-1:0] IDX_TXP = 10'd72;
    localparam logic [IDX_W-1:0] IDX_RXB = 10'd80;
    localparam logic [IDX_W-1:0] IDX_RXP = 10'd88;

    localparam int RING_SLOTS  = 8;
    localparam int TX_HALT_TOP = 31;
    localparam int RX_HALT_TOP = 23;

    typedef enum logic [1:0] {
        ACC_RW,
        ACC_WO,
        ACC_W1C,
        ACC_RO
    } acc_e;

    function automatic acc_e acc_of(logic [IDX_W-1:0] idx);
        acc_e a;
        a = ACC_RO;
        if (idx == IDX_EVT || idx == IDX_TXS || idx == IDX_RXS) a = ACC_W1C;
        else if (idx == IDX_MSK || idx == IDX_CFG) a = ACC_RW;
        else if (idx == IDX_CMD) a = ACC_WO;
        else if (idx >= IDX_TXB && idx < IDX_TXP) a = ACC_RW;
        else if (idx >= IDX_RXB && idx < IDX_RXP) a = ACC_RW;
        return a;
    endfunction

endpackage

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl #(
    parameter int          DW       = 32,
    parameter logic [31:0] TX_GRP   = 32'h0000_00FF,
    parameter logic [31:0] RX_GRP   = 32'h0000_FF00,
    parameter logic [31:0] ERR_GRP  = 32'hFFFF_0000,
    parameter logic [31:0] EVT_RST  = 32'h0,
    parameter logic [31:0] MSK_RST  = 32'h0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          evt_we_i,
    input  logic          msk_we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] set_i,
    output logic [DW-1:0] evt_o,
    output logic [DW-1:0] msk_o,
    output logic          irq_tx_o,
    output logic          irq_rx_o,
    output logic          irq_err_o
);

    typedef struct packed {
        logic [DW-1:0] evt;
        logic [DW-1:0] msk;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [DW-1:0] clr_mask;
    logic [DW-1:0] active;

    always_comb begin
        st_d     = st_q;
        clr_mask = evt_we_i ? wdata_i : '0;
        st_d.evt = (st_q.evt & ~clr_mask) | set_i;
        if (msk_we_i) st_d.msk = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.evt <= EVT_RST[DW-1:0];
            st_q.msk <= MSK_RST[DW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.evt & st_q.msk;
    assign irq_tx_o  = |(active & TX_GRP[DW-1:0]);
    assign irq_rx_o  = |(active & RX_GRP[DW-1:0]);
    assign irq_err_o = |(active & ERR_GRP[DW-1:0]);
    assign evt_o     = st_q.evt;
    assign msk_o     = st_q.msk;

    // R6
    evt_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_we_i |=> ((evt_o & $past(wdata_i & ~set_i)) == '0));

    // R7
    evt_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((evt_o & $past(set_i)) == $past(set_i)));

    // R4
    msk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !msk_we_i |=> $stable(msk_o));

endmodule

// File: rtl/nic_halt_ctl.sv
module nic_halt_ctl #(
    parameter int           N             = 8,
    parameter int           DW            = 32,
    parameter int           TOP           = 31,
    parameter bit           ONLY_IF_CLEAR = 1'b0,
    parameter logic [7:0]   FLAG_RST      = 8'hFF
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  set_i,
    output logic [DW-1:0] stat_o,
    output logic [N-1:0]  restart_o
);

    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] pulse;
    } halt_st_t;

    halt_st_t st_d, st_q;
    logic [N-1:0] wbit;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            wbit[i]        = we_i & wdata_i[TOP-i];
            st_d.pulse[i]  = ONLY_IF_CLEAR ? (wbit[i] & ~st_q.flags[i]) : wbit[i];
            st_d.flags[i]  = (st_q.flags[i] & ~wbit[i]) | set_i[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.flags <= FLAG_RST[N-1:0];
            st_q.pulse <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_o = '0;
        for (int i = 0; i < N; i++) begin
            stat_o[TOP-i] = st_q.flags[i];
        end
    end

    assign restart_o = st_q.pulse;

    for (genvar g = 0; g < N; g++) begin : g_ring_chk
        // R9
        restart_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            restart_o[g] |-> $past(we_i && wdata_i[TOP-g]));

        // R11
        halt_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[g] |=> stat_o[TOP-g]);

        if (ONLY_IF_CLEAR) begin : g_cond
            // R10
            restart_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                restart_o[g] |-> !$past(stat_o[TOP-g]));
        end
    end

endmodule

// File: rtl/nic_ring_ptrs.sv
module nic_ring_ptrs #(
    parameter int N     = 8,
    parameter int DW    = 32,
    parameter int ALIGN = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N-1:0]          base_we_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [N-1:0][DW-1:0]  base_o,
    output logic [N-1:0][DW-1:0]  ptr_o
);

    localparam logic [DW-1:0] LOW_MASK = DW'((1 << ALIGN) - 1);

    typedef struct packed {
        logic [N-1:0][DW-1:0] base;
        logic [N-1:0][DW-1:0] ptr;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic [DW-1:0] aligned;

    always_comb begin
        st_d    = st_q;
        aligned = wdata_i & ~LOW_MASK;
        for (int n = 0; n < N; n++) begin
            if (base_we_i[n]) begin
                st_d.base[n] = aligned;
                st_d.ptr[n]  = aligned;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign base_o = st_q.base;
    assign ptr_o  = st_q.ptr;

    for (genvar g = 0; g < N; g++) begin : g_ptr_chk
        // R12
        ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            base_we_i[g] |=> (ptr_o[g] == ($past(wdata_i) & ~LOW_MASK)));

        // R12
        ptr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !base_we_i[g] |=> $stable(ptr_o[g]));
    end

endmodule

// File: rtl/nic_stat_regfile.sv
module nic_stat_regfile
    import nic_regs_pkg::*;
#(
    parameter int          NRING       = 8,
    parameter int          AW          = 12,
    parameter int          DW          = 32,
    parameter logic [31:0] TX_GRP      = 32'h0000_00FF,
    parameter logic [31:0] RX_GRP      = 32'h0000_FF00,
    parameter logic [31:0] ERR_GRP     = 32'hFFFF_0000,
    parameter logic [31:0] EVT_RST     = 32'h0000_0000,
    parameter logic [31:0] MSK_RST     = 32'h0000_0000,
    parameter logic [7:0]  TX_HALT_RST = 8'hFF,
    parameter logic [7:0]  RX_HALT_RST = 8'hFF,
    parameter logic [31:0] CFG_RST     = 32'h0000_0100,
    parameter logic [31:0] ID_VALUE    = 32'h0A5C_0003
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic [DW-1:0]    evt_set_i,
    input  logic [NRING-1:0] tx_halt_set_i,
    input  logic [NRING-1:0] rx_halt_set_i,
    output logic [NRING-1:0] tx_restart_o,
    output logic [NRING-1:0] rx_restart_o,
    output logic             irq_tx_o,
    output logic             irq_rx_o,
    output logic             irq_err_o,
    output logic [DW-1:0]    cfg_o,
    output logic [DW-1:0]    cmd_o
);

    localparam int LIDX_W = AW - 2;

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] cmd;
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [IDX_W-1:0]  idx;
    logic              wr, rd;
    logic              wr_evt, wr_msk, wr_txs, wr_rxs;
    logic [NRING-1:0]  txb_we, rxb_we;
    logic [DW-1:0]     evt_q, msk_q, txs_q, rxs_q;
    logic [NRING-1:0][DW-1:0] txb_q, txp_q, rxb_q, rxp_q;
    logic [DW-1:0]     rd_raw, rd_val;

    assign idx    = IDX_W'(addr_i[AW-1:AW-LIDX_W]);
    assign wr     = req_i & we_i;
    assign rd     = req_i & ~we_i;
    assign wr_evt = wr && (idx == IDX_EVT);
    assign wr_msk = wr && (idx == IDX_MSK);
    assign wr_txs = wr && (idx == IDX_TXS);
    assign wr_rxs = wr && (idx == IDX_RXS);

    always_comb begin
        for (int n = 0; n < NRING; n++) begin
            txb_we[n] = wr && (idx == IDX_TXB + IDX_W'(n));
            rxb_we[n] = wr && (idx == IDX_RXB + IDX_W'(n));
        end
    end

    nic_irq_ctl #(
        .DW      (DW),
        .TX_GRP  (TX_GRP),
        .RX_GRP  (RX_GRP),
        .ERR_GRP (ERR_GRP),
        .EVT_RST (EVT_RST),
        .MSK_RST (MSK_RST)
    ) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_we_i  (wr_evt),
        .msk_we_i  (wr_msk),
        .wdata_i   (wdata_i),
        .set_i     (evt_set_i),
        .evt_o     (evt_q),
        .msk_o     (msk_q),
        .irq_tx_o  (irq_tx_o),
        .irq_rx_o  (irq_rx_o),
        .irq_err_o (irq_err_o)
    );

    nic_halt_ctl #(
        .N             (NRING),
        .DW            (DW),
        .TOP           (TX_HALT_TOP),
        .ONLY_IF_CLEAR (1'b0),
        .FLAG_RST      (TX_HALT_RST)
    ) u_tx_halt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (wr_txs),
        .wdata_i   (wdata_i),
        .set_i     (tx_halt_set_i),
        .stat_o    (txs_q),
        .restart_o (tx_restart_o)
    );

    nic_halt_ctl #(
        .N             (NRING),
        .DW            (DW),
        .TOP           (RX_HALT_TOP),
        .ONLY_IF_CLEAR (1'b1),
        .FLAG_RST      (RX_HALT_RST)
    ) u_rx_halt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (wr_rxs),
        .wdata_i   (wdata_i),
        .set_i     (rx_halt_set_i),
        .stat_o    (rxs_q),
        .restart_o (rx_restart_o)
    );

    nic_ring_ptrs #(
        .N  (NRING),
        .DW (DW)
    ) u_tx_ring (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .base_we_i (txb_we),
        .wdata_i   (wdata_i),
        .base_o    (txb_q),
        .ptr_o     (txp_q)
    );

    nic_ring_ptrs #(
        .N  (NRING),
        .DW (DW)
    ) u_rx_ring (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .base_we_i (rxb_we),
        .wdata_i   (wdata_i),
        .base_o    (rxb_q),
        .ptr_o     (rxp_q)
    );

    // Read multiplexer, then the per-register policy hides write-only words.
    always_comb begin
        rd_raw = '0;
        if (idx == IDX_EVT)      rd_raw = evt_q;
        else if (idx == IDX_MSK) rd_raw = msk_q;
        else if (idx == IDX_TXS) rd_raw = txs_q;
        else if (idx == IDX_RXS) rd_raw = rxs_q;
        else if (idx == IDX_CFG) rd_raw = st_q.cfg;
        else if (idx == IDX_CMD) rd_raw = st_q.cmd;
        else if (idx == IDX_ID)  rd_raw = ID_VALUE[DW-1:0];
        for (int n = 0; n < NRING; n++) begin
            if (idx == IDX_TXB + IDX_W'(n)) rd_raw = txb_q[n];
            if (idx == IDX_TXP + IDX_W'(n)) rd_raw = txp_q[n];
            if (idx == IDX_RXB + IDX_W'(n)) rd_raw = rxb_q[n];
            if (idx == IDX_RXP + IDX_W'(n)) rd_raw = rxp_q[n];
        end
        rd_val = (acc_of(idx) == ACC_WO) ? '0 : rd_raw;
    end

    always_comb begin
        st_d = st_q;
        if (wr && idx == IDX_CFG && acc_of(idx) == ACC_RW) st_d.cfg = wdata_i;
        if (wr && idx == IDX_CMD && acc_of(idx) == ACC_WO) st_d.cmd = wdata_i;
        if (rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cfg   <= CFG_RST[DW-1:0];
            st_q.cmd   <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign cfg_o   = st_q.cfg;
    assign cmd_o   = st_q.cmd;

    // R3
    rd_wo_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd && idx == IDX_CMD) |=> (rdata_o == '0));

    // R5
    rd_id_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd && idx == IDX_ID) |=> (rdata_o == ID_VALUE[DW-1:0]));

    // R2
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd |=> $stable(rdata_o));

endmodule

// File: tb/nic_stat_regfile_tb.sv
`timescale 1ns/1ps
module nic_stat_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] evt_set = '0;
    logic [7:0]  txset = '0, rxset = '0;
    logic [31:0] rdata, cfg_o, cmd_o;
    logic [7:0]  txr, rxr;
    logic        irq_tx, irq_rx, irq_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nic_stat_regfile u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .evt_set_i(evt_set),
        .tx_halt_set_i(txset), .rx_halt_set_i(rxset),
        .tx_restart_o(txr), .rx_restart_o(rxr),
        .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err),
        .cfg_o(cfg_o), .cmd_o(cmd_o)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_evt, m_msk, m_cfg, m_cmd, m_rd;
    logic [7:0]  m_txf, m_rxf, m_txr, m_rxr;
    logic [31:0] m_tb [8];
    logic [31:0] m_tp [8];
    logic [31:0] m_rb [8];
    logic [31:0] m_rp [8];

    function automatic logic [31:0] m_read(int ix);
        logic [31:0] v;
        v = 32'h0;
        case (ix)
            0: v = m_evt;
            1: v = m_msk;
            2: for (int i = 0; i < 8; i++) v[31-i] = m_txf[i];
            3: for (int i = 0; i < 8; i++) v[23-i] = m_rxf[i];
            4: v = m_cfg;
            5: v = 32'h0;
            6: v = 32'h0A5C_0003;
            default: begin
                if (ix >= 64 && ix < 72) v = m_tb[ix-64];
                else if (ix >= 72 && ix < 80) v = m_tp[ix-72];
                else if (ix >= 80 && ix < 88) v = m_rb[ix-80];
                else if (ix >= 88 && ix < 96) v = m_rp[ix-88];
            end
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        int ix;
        logic w, r;
        logic [7:0] ntxf, nrxf, ntxr, nrxr;
        if (!rst_n) begin
            m_evt <= 0; m_msk <= 0; m_cfg <= 32'h100; m_cmd <= 0; m_rd <= 0;
            m_txf <= 8'hFF; m_rxf <= 8'hFF; m_txr <= 0; m_rxr <= 0;
            for (int n = 0; n < 8; n++) begin
                m_tb[n] <= 0; m_tp[n] <= 0; m_rb[n] <= 0; m_rp[n] <= 0;
            end
        end else begin
            ix = int'(addr[11:2]);
            w = req && we;
            r = req && !we;
            ntxf = m_txf; nrxf = m_rxf; ntxr = 0; nrxr = 0;
            for (int i = 0; i < 8; i++) begin
                if (w && ix == 2 && wdata[31-i]) begin ntxr[i] = 1; ntxf[i] = 0; end
                if (w && ix == 3 && wdata[23-i]) begin
                    if (!m_rxf[i]) nrxr[i] = 1;
                    nrxf[i] = 0;
                end
            end
            m_txf <= ntxf | txset;
            m_rxf <= nrxf | rxset;
            m_txr <= ntxr;
            m_rxr <= nrxr;
            m_evt <= ((w && ix == 0) ? (m_evt & ~wdata) : m_evt) | evt_set;
            if (w && ix == 1) m_msk <= wdata;
            if (w && ix == 4) m_cfg <= wdata;
            if (w && ix == 5) m_cmd <= wdata;
            for (int n = 0; n < 8; n++) begin
                if (w && ix == 64 + n) begin m_tb[n] <= wdata & ~32'h7; m_tp[n] <= wdata & ~32'h7; end
                if (w && ix == 80 + n) begin m_rb[n] <= wdata & ~32'h7; m_rp[n] <= wdata & ~32'h7; end
            end
            if (r) m_rd <= m_read(ix);
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every output with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 rdata", rdata, m_rd);
            chk("R8 irq_tx", {31'h0, irq_tx}, {31'h0, |(m_evt & m_msk & 32'h0000_00FF)});
            chk("R8 irq_rx", {31'h0, irq_rx}, {31'h0, |(m_evt & m_msk & 32'h0000_FF00)});
            chk("R8 irq_err", {31'h0, irq_err}, {31'h0, |(m_evt & m_msk & 32'hFFFF_0000)});
            chk("R9 tx_restart", {24'h0, txr}, {24'h0, m_txr});
            chk("R10 rx_restart", {24'h0, rxr}, {24'h0, m_rxr});
            chk("R3 cmd_o", cmd_o, m_cmd);
            chk("R4 cfg_o", cfg_o, m_cfg);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(int ix, logic [31:0] d);
        @(negedge clk);
        req = 1; we = 1; addr = 12'(ix * 4); wdata = d;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic rdc(int ix, logic [31:0] exp, string tag);
        @(negedge clk);
        req = 1; we = 0; addr = 12'(ix * 4);
        @(negedge clk);
        req = 0;
        chk(tag, rdata, exp);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 irq", {29'h0, irq_tx, irq_rx, irq_err}, 0);
        chk("R1 restart", {16'h0, txr, rxr}, 0);
        rdc(0, 32'h0, "R1 event");
        rdc(1, 32'h0, "R1 mask");
        rdc(2, 32'hFF00_0000, "R1 txstat");
        rdc(3, 32'h00FF_0000, "R1 rxstat");
        rdc(4, 32'h0000_0100, "R1 cfg");
        rdc(6, 32'h0A5C_0003, "R1 id");
        rdc(64, 32'h0, "R1 txbase0");
        rdc(95, 32'h0, "R1 rxptr7");

        // R4 read/write words
        wr(4, 32'hCAFE_F00D);
        rdc(4, 32'hCAFE_F00D, "R4 cfg");
        wr(1, 32'hFFFF_FFFF);
        rdc(1, 32'hFFFF_FFFF, "R4 mask");

        // R3 write-only
        wr(5, 32'h1234_5678);
        chk("R3 cmd_o", cmd_o, 32'h1234_5678);
        rdc(5, 32'h0, "R3 cmd read");

        // R5 ignored writes
        wr(6, 32'h0);
        rdc(6, 32'h0A5C_0003, "R5 id");
        wr(74, 32'h1111_1111);
        rdc(74, 32'h0, "R5 txptr2");
        wr(200, 32'hFFFF_FFFF);
        rdc(200, 32'h0, "R2 undefined read");

        // R7 / R8 events and interrupts
        @(negedge clk); evt_set = 32'h0000_0001;
        @(negedge clk); evt_set = 0;
        chk("R8 tx line", {29'h0, irq_tx, irq_rx, irq_err}, 32'h4);
        @(negedge clk); evt_set = 32'h0000_0100;
        @(negedge clk); evt_set = 0;
        chk("R8 rx line", {31'h0, irq_rx}, 1);
        @(negedge clk); evt_set = 32'h0001_0000;
        @(negedge clk); evt_set = 0;
        chk("R8 err line", {31'h0, irq_err}, 1);
        rdc(0, 32'h0001_0101, "R7 event set");
        // R6 clear
        wr(0, 32'h0000_0101);
        chk("R6 tx line cleared", {29'h0, irq_tx, irq_rx, irq_err}, 32'h1);
        rdc(0, 32'h0001_0000, "R6 event w1c");
        wr(1, 32'h0);
        chk("R8 masked", {31'h0, irq_err}, 0);
        // R7 set wins over clear
        @(negedge clk);
        req = 1; we = 1; addr = 12'h000; wdata = 32'h0001_0000; evt_set = 32'h0001_0000;
        @(negedge clk);
        req = 0; we = 0; evt_set = 0;
        rdc(0, 32'h0001_0000, "R7 set wins");
        wr(0, 32'hFFFF_FFFF);
        rdc(0, 32'h0, "R6 clear all");

        // R9 transmit halt
        wr(2, 32'h0500_0000);
        chk("R9 pulses rings 5,7", {24'h0, txr}, 32'hA0);
        @(negedge clk);
        chk("R9 one cycle", {24'h0, txr}, 0);
        rdc(2, 32'hFA00_0000, "R9 flags cleared");
        wr(2, 32'h0500_0000);
        chk("R9 pulse when clear", {24'h0, txr}, 32'hA0);

        // R10 receive halt
        wr(3, 32'h0080_0000);
        chk("R10 no pulse while halted", {24'h0, rxr}, 0);
        rdc(3, 32'h007F_0000, "R10 flag cleared");
        wr(3, 32'h00C0_0000);
        chk("R10 pulse only ring0", {24'h0, rxr}, 32'h01);
        rdc(3, 32'h003F_0000, "R10 ring1 cleared");

        // R11 halt set wins
        @(negedge clk);
        req = 1; we = 1; addr = 12'(3 * 4); wdata = 32'h0080_0000; rxset = 8'h01;
        @(negedge clk);
        req = 0; we = 0; rxset = 0;
        chk("R11 rx pulse", {24'h0, rxr}, 32'h01);
        rdc(3, 32'h00BF_0000, "R11 rx set wins");
        @(negedge clk); txset = 8'h20;
        @(negedge clk); txset = 0;
        rdc(2, 32'hFE00_0000, "R11 tx set");

        // R12 base and pointer
        wr(67, 32'hDEAD_BEEF);
        rdc(67, 32'hDEAD_BEE8, "R12 txbase3");
        rdc(75, 32'hDEAD_BEE8, "R12 txptr3");
        wr(87, 32'h1234_567F);
        rdc(87, 32'h1234_5678, "R12 rxbase7");
        rdc(95, 32'h1234_5678, "R12 rxptr7");
        rdc(64, 32'h0, "R12 other ring");

        // Random phase, compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            int pick;
            @(negedge clk);
            pick = int'($urandom % 16);
            req   = ($urandom % 3) != 0;
            we    = $urandom % 2;
            case (pick)
                0,1,2,3,4,5,6: addr = 12'(pick * 4);
                7:  addr = 12'((64 + int'($urandom % 8)) * 4);
                8:  addr = 12'((72 + int'($urandom % 8)) * 4);
                9:  addr = 12'((80 + int'($urandom % 8)) * 4);
                10: addr = 12'((88 + int'($urandom % 8)) * 4);
                11: addr = 12'($urandom);
                default: addr = 12'(int'($urandom % 4) * 4);
            endcase
            wdata   = $urandom;
            evt_set = (($urandom % 4) == 0) ? ($urandom & $urandom) : 32'h0;
            txset   = (($urandom % 5) == 0) ? 8'($urandom) : 8'h0;
            rxset   = (($urandom % 5) == 0) ? 8'($urandom) : 8'h0;
        end
        @(negedge clk);
        req = 0; we = 0; evt_set = 0; txset = 0; rxset = 0;
        repeat (3) @(negedge clk);
        report();
    end

endmodule